// File: doc/BRIEF.md
# Modulo Timer Overflow Status Unit

This block is a 16-bit timer counter with an 8-bit control and status register, all reached over a simple byte-wide register bus. A prescaler first divides a selectable clock enable by a power of two. The counter then runs either upward and wraps back to zero past a programmable limit, or upward and downward between zero and that limit for center-aligned waveforms. Each wrap or reversal at the limit sets a sticky overflow flag. The flag drives an active-high interrupt request when the interrupt enable bit is set.

Software clears the flag with a guarded handshake. It must first read the control register while the flag is set, which arms the clear. It then writes the register with the flag bit at 0. If a new overflow arrives between those two accesses, the clear is cancelled, so no overflow event is lost. Clock sources are synchronous one-cycle enable pulses: every clock, a fixed-rate tick or an external tick.

Top module: `modulo_timer`

## Requirements
- R1: With the center bit at 0 and a nonzero limit M, each counter tick adds one, and the tick that finds the count at M (or above) loads 0 and sets the overflow flag.
- R2: A limit of 0x0000 makes the counter free-running: it wraps from 0xFFFF to 0x0000 and sets the overflow flag on that wrap.
- R3: With the center bit at 1, the counter counts up to M and then down to 0 and repeats (0,1,..,M,M-1,..,0,1,..). The overflow flag sets on the tick that turns the count from M back to M-1.
- R4: The clock source field (ctrl bits 4:3) selects where counter ticks come from: 00 stops the counter, 01 uses every clock, 10 uses the fixed_tick input and 11 uses the ext_tick input. Pulses from a source that is not selected have no effect.
- R5: The prescale field (ctrl bits 2:0, value P) makes the counter advance once per 2^P pulses of the selected source. The divider restarts from zero whenever the source field is 00.
- R6: The overflow flag (ctrl bit 7) clears only when a write with bit 7 at 0 follows a read of the control register that returned bit 7 as 1.
- R7: An overflow that occurs after the arming read and before the clearing write cancels the clear, so the flag is still 1 after that write.
- R8: Writing 1 to bit 7 never changes the flag. A write to the control register that no arming read preceded leaves the flag unchanged. Either kind of write consumes any pending arming.
- R9: irq is 1 exactly when the overflow flag and the interrupt enable bit (ctrl bit 6) are both 1.
- R10: Register addresses are 0 control, 1 count high byte, 2 count low byte, 3 limit high byte, 4 limit low byte. Read data appears on bus_rdata one clock after the read strobe. After reset every register reads 0x00. A control write always updates bits 6:0.
- R11: Any write to address 1 or 2 resets the count to 0 and restarts the up/down direction as upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| fixed_tick | input | 1 | Fixed-rate clock enable pulse (source 10) |
| ext_tick | input | 1 | External clock enable pulse (source 11) |
| irq | output | 1 | Overflow interrupt request, active high |

## Verification
The bench steps the counter with single external pulses, so it can place an overflow exactly between the arming read and the clearing write. A design without that guard would clear the flag there and drop the interrupt. It also writes the control register with no arming read, and with bit 7 at 1 after an arming read; a design that treats these as clears would lower irq early. Center mode is walked tick by tick through the reversal, and a design that flags at zero or wraps would return the wrong count. A 65,536-cycle free-running pass on the bus clock tests the 0xFFFF wrap with a zero limit, and prescale values 2 and 7 test the tick positions where an off-by-one divider would move the count one pulse early or late.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PS_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_LIM_HI = 3'd3,
    A_LIM_LO = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_BUS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic            ovf;
    logic            ie;
    logic            center;
    clk_src_e        src;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler
  import mtu_pkg::*;
#(
  parameter int unsigned SEL_W = PS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  clk_src_e         src_i,
  input  logic [SEL_W-1:0] ps_i,
  input  logic             fixed_tick_i,
  input  logic             ext_tick_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic             tick_in;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    unique case (src_i)
      SRC_BUS:   tick_in = 1'b1;
      SRC_FIXED: tick_in = fixed_tick_i;
      SRC_EXT:   tick_in = ext_tick_i;
      default:   tick_in = 1'b0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < int'(DIV_W); i++) begin
      mask[i] = (i < int'(ps_i));
    end
  end

  assign tick_o = tick_in && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || src_i == SRC_OFF) begin
      div_q <= '0;
    end else if (tick_in) begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  // R5: a divided tick only ever accompanies a source pulse
  assert_tick_needs_src_R5: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (src_i != SRC_OFF));
  // R4: without a source pulse the divider holds
  assert_div_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick_in && src_i != SRC_OFF) |=> $stable(div_q) || $past(src_i) != src_i || rst);
endmodule

// File: rtl/mtu_counter.sv
module mtu_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, top;
  logic             down_q, down_n;

  assign top = (limit_i == '0) ? '1 : limit_i;

  always_comb begin
    cnt_n  = cnt_q;
    down_n = center_i ? down_q : 1'b0;
    ovf_o  = 1'b0;
    if (tick_i) begin
      if (!center_i) begin
        if (cnt_q >= top) begin
          cnt_n = '0;
          ovf_o = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else if (!down_q) begin
        if (cnt_q >= top) begin
          cnt_n  = cnt_q - CNT_W'(1);
          down_n = 1'b1;
          ovf_o  = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_n  = CNT_W'(1);
          down_n = 1'b0;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
    end
  end

  assign cnt_o = cnt_q;

  // R4: no tick, no movement
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_o));
  // R1: an up-mode overflow lands on zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !center_i && !clr_i) |=> cnt_o == '0);
  // R3: center mode moves by exactly one per tick
  assert_center_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && center_i && !clr_i) |=>
      (cnt_o == $past(cnt_o) + CNT_W'(1)) || (cnt_o == $past(cnt_o) - CNT_W'(1)));
  // R11: a clear strobe empties the counter
  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/mtu_regs.sv
module mtu_regs
  import mtu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ovf_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              cnt_clr_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  ctrl_t             ctrl_q, wr_ctrl_val;
  logic              arm_q;
  logic [CNT_W-1:0]  limit_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              wr_ctrl, rd_ctrl;

  assign wr_ctrl     = wr_i && (addr_i == A_CTRL);
  assign rd_ctrl     = rd_i && (addr_i == A_CTRL);
  assign wr_ctrl_val = ctrl_t'(wdata_i);
  assign cnt_clr_o   = wr_i && ((addr_i == A_CNT_HI) || (addr_i == A_CNT_LO));

  // control fields other than the flag
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.ie     <= 1'b0;
      ctrl_q.center <= 1'b0;
      ctrl_q.src    <= SRC_OFF;
      ctrl_q.ps     <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.ie     <= wr_ctrl_val.ie;
      ctrl_q.center <= wr_ctrl_val.center;
      ctrl_q.src    <= wr_ctrl_val.src;
      ctrl_q.ps     <= wr_ctrl_val.ps;
    end
  end

  // overflow flag with guarded two-step clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.ovf <= 1'b0;
      arm_q      <= 1'b0;
    end else if (ovf_i) begin
      ctrl_q.ovf <= 1'b1;
      arm_q      <= 1'b0;
    end else if (wr_ctrl) begin
      if (arm_q && !wr_ctrl_val.ovf) ctrl_q.ovf <= 1'b0;
      arm_q <= 1'b0;
    end else if (rd_ctrl && ctrl_q.ovf) begin
      arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
    end else if (wr_i && addr_i == A_LIM_LO) begin
      limit_q[BYTE_W-1:0] <= wdata_i;
    end else if (wr_i && addr_i == A_LIM_HI) begin
      limit_q[CNT_W-1:BYTE_W] <= HI_W'(wdata_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      unique case (addr_i)
        A_CTRL:   rdata_q <= ctrl_q;
        A_CNT_HI: rdata_q <= BYTE_W'(cnt_i >> BYTE_W);
        A_CNT_LO: rdata_q <= cnt_i[BYTE_W-1:0];
        A_LIM_HI: rdata_q <= BYTE_W'(limit_q >> BYTE_W);
        A_LIM_LO: rdata_q <= limit_q[BYTE_W-1:0];
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign limit_o = limit_q;
  assign irq_o   = ctrl_q.ovf && ctrl_q.ie;

  // R1: an overflow event always leaves the flag set
  assert_flag_sets_R1: assert property (@(posedge clk) disable iff (rst)
    ovf_i |=> ctrl_q.ovf);
  // R6: the flag only falls after an armed write of 0
  assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q.ovf) |-> ($past(arm_q) && $past(wr_ctrl) && !$past(wdata_i[BYTE_W-1])));
  // R8: a write of 1 to the flag keeps it
  assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata_i[BYTE_W-1] && ctrl_q.ovf) |=> ctrl_q.ovf);
  // R7: an overflow drops any pending arming
  assert_ovf_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_i |=> !arm_q);
  // R9: an interrupt request means the enable is set
  assert_irq_enable_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ctrl_q.ie);
endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
  import mtu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              fixed_tick,
  input  logic              ext_tick,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] limit, cnt;
  logic             tick, ovf, cnt_clr;

  mtu_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .wdata_i  (bus_wdata),
    .ovf_i    (ovf),
    .cnt_i    (cnt),
    .rdata_o  (bus_rdata),
    .ctrl_o   (ctrl),
    .limit_o  (limit),
    .cnt_clr_o(cnt_clr),
    .irq_o    (irq)
  );

  mtu_prescaler #(.SEL_W(PS_W)) u_pre (
    .clk         (clk),
    .rst         (rst),
    .src_i       (ctrl.src),
    .ps_i        (ctrl.ps),
    .fixed_tick_i(fixed_tick),
    .ext_tick_i  (ext_tick),
    .tick_o      (tick)
  );

  mtu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .center_i(ctrl.center),
    .clr_i   (cnt_clr),
    .limit_i (limit),
    .cnt_o   (cnt),
    .ovf_o   (ovf)
  );
endmodule

// File: tb/test_modulo_timer.sv
module test_modulo_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       fixed_tick = 1'b0, ext_tick = 1'b0;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #2 clk = ~clk;

  modulo_timer i_modulo_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fixed_tick(fixed_tick),
    .ext_tick(ext_tick), .irq(irq)
  );

  // monitor: read data is due one edge after the strobe
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: unexpected read data act=%02h exp=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: read act=%02h exp=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ext_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      ext_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      ext_tick = 1'b0;
    end
  endtask

  task automatic fixed_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      fixed_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      fixed_tick = 1'b0;
    end
  endtask

  task automatic check_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq act=%0b exp=%0b", t, irq, e);
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    bus_read(3'd0, 8'h00, "R10 ctrl reset");
    bus_read(3'd4, 8'h00, "R10 limit reset");
    bus_read(3'd2, 8'h00, "R10 count reset");
    check_irq(1'b0, "R10 irq reset");

    // R1 up mode with limit 4 on external ticks
    bus_write(3'd4, 8'h04);
    bus_write(3'd3, 8'h00);
    bus_read(3'd4, 8'h04, "R10 limit readback");
    bus_write(3'd0, 8'h58);
    bus_read(3'd0, 8'h58, "R10 ctrl fields");
    ext_pulse(4);
    bus_read(3'd2, 8'h04, "R1 count at limit");
    check_irq(1'b0, "R1 no flag before wrap");
    ext_pulse(1);
    bus_read(3'd2, 8'h00, "R1 wrap to zero");
    check_irq(1'b1, "R1 R9 flag and irq on wrap");

    // R8 write without arming read
    bus_write(3'd0, 8'h58);
    check_irq(1'b1, "R8 unarmed write keeps flag");
    // R8 write of 1 after arming
    bus_read(3'd0, 8'hD8, "R6 arming read");
    bus_write(3'd0, 8'hD8);
    check_irq(1'b1, "R8 write one keeps flag");
    // R6 proper two-step clear
    bus_read(3'd0, 8'hD8, "R6 arming read 2");
    bus_write(3'd0, 8'h58);
    check_irq(1'b0, "R6 flag cleared");
    bus_read(3'd0, 8'h58, "R6 ctrl after clear");

    // R7 overflow between read and write
    ext_pulse(5);
    check_irq(1'b1, "R7 setup overflow");
    ext_pulse(4);
    bus_read(3'd0, 8'hD8, "R7 arming read");
    ext_pulse(1);
    bus_write(3'd0, 8'h58);
    check_irq(1'b1, "R7 clear cancelled");
    bus_read(3'd0, 8'hD8, "R7 flag still set");
    bus_write(3'd0, 8'h58);
    check_irq(1'b0, "R7 later clear works");

    // R4 stopped source and fixed tick source
    bus_write(3'd0, 8'h40);
    ext_pulse(3);
    bus_read(3'd2, 8'h00, "R4 stopped counter");
    bus_write(3'd0, 8'h50);
    fixed_pulse(2);
    bus_read(3'd2, 8'h02, "R4 fixed tick source");
    ext_pulse(3);
    bus_read(3'd2, 8'h02, "R4 ext ignored on fixed source");

    // R11 counter clear
    bus_write(3'd2, 8'hA5);
    bus_read(3'd2, 8'h00, "R11 count cleared");

    // R5 prescale 2 and 7
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'h00);
    bus_write(3'd0, 8'h1A);
    ext_pulse(3);
    bus_read(3'd2, 8'h00, "R5 ps2 three pulses");
    ext_pulse(1);
    bus_read(3'd2, 8'h01, "R5 ps2 fourth pulse");
    ext_pulse(4);
    bus_read(3'd2, 8'h02, "R5 ps2 eighth pulse");
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'h00);
    bus_write(3'd0, 8'h1F);
    ext_pulse(127);
    bus_read(3'd2, 8'h00, "R5 ps7 127 pulses");
    ext_pulse(1);
    bus_read(3'd2, 8'h01, "R5 ps7 128th pulse");

    // R3 center mode, limit 3
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'h00);
    bus_write(3'd4, 8'h03);
    bus_write(3'd0, 8'h38);
    ext_pulse(3);
    bus_read(3'd2, 8'h03, "R3 up to limit");
    bus_read(3'd0, 8'h38, "R3 no flag at limit");
    ext_pulse(1);
    bus_read(3'd2, 8'h02, "R3 reversal");
    check_irq(1'b0, "R9 flag without enable");
    ext_pulse(2);
    bus_read(3'd2, 8'h00, "R3 down to zero");
    ext_pulse(1);
    bus_read(3'd2, 8'h01, "R3 up again");
    bus_read(3'd0, 8'hB8, "R3 flag at reversal");
    bus_write(3'd0, 8'hF8);
    check_irq(1'b1, "R9 enable raises irq");
    bus_read(3'd0, 8'hF8, "R6 arm before shutdown");
    bus_write(3'd0, 8'h00);
    check_irq(1'b0, "R6 clear in center mode");

    // R2 free running on the bus clock, limit 0
    bus_write(3'd4, 8'h00);
    bus_write(3'd2, 8'h00);
    bus_write(3'd0, 8'h48);
    repeat (65535) @(negedge clk);
    check_irq(1'b0, "R2 no flag at 0xFFFF");
    @(negedge clk);
    check_irq(1'b1, "R2 flag on 0xFFFF wrap");
    bus_write(3'd0, 8'h40);
    bus_read(3'd2, 8'h01, "R2 count low after wrap");
    bus_read(3'd1, 8'h00, "R2 count high after wrap");
    bus_read(3'd0, 8'hC0, "R2 ctrl after wrap");

    settle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule